// File: doc/BRIEF.md
# Five-Level Stacked-Carrier PWM Modulator

This block turns a signed reference sample into a five-level switching command for one leg of a multilevel inverter. Three copies drive three phases. The reference is first scaled by an amplitude setting. It is then compared against four triangular carriers that are stacked one above another across the reference range. Each comparison gives an intermediate level, and the four intermediate levels are added to give the commanded output level, from -2 to +2 units.

All four carriers come from one shared up/down counter, each with its own fixed offset, so they reverse direction together. The carrier peak count sets the carrier frequency: one full triangle lasts twice the peak count in clock cycles. The output level is decoded into eight gate commands. Three of them are chosen freely. Three are the complements of those, and the last two are three-input products of the others.

The comparison results, the level and the gates are registered once. The gates therefore follow the reference with one clock of latency. Dead-time, sensing and capacitor balancing are handled elsewhere.

Top module: `mlpwm_leg`

## Requirements
- R1: One counter is shared by all four carriers. It leaves reset at 0 and rises by one per clock up to `pk`, then falls by one per clock down to 0, then rises again. For example, with `pk`=3 it runs 0,1,2,3,2,1,0,1. With `pk`=0 it holds at 0.
- R2: With counter value c, the four carriers are: carrier 1 (top) = `pk`+c, carrier 2 = c, carrier 3 = c-`pk`, carrier 4 (bottom) = c-2·`pk`.
- R3: The effective reference is floor(`ref_in`·`amp`/2^(AW-1)). An `amp` of 128 (with AW=8) is unity gain, and an `amp` of 0 gives an effective reference of 0.
- R4: A carrier counts as passed only when the effective reference is strictly greater than it; equality counts as below. The intermediate levels are: carrier 1 gives +1 if passed, else 0. Carrier 2 gives +2 if passed, else +1. Carrier 3 gives 0 if passed, else -1. Carrier 4 gives -1 if passed, else -2.
- R5: `level` is the sum of the four intermediate levels and always lies in -2..+2. It is registered, so it reflects the counter value and inputs present before the latest rising clock edge.
- R6: `gate[i-1]` is gate i. Gates 1,2,3 are 1,1,1 for level +2; 1,1,0 for +1; 0,1,0 for 0; 0,0,1 for -1; and 0,0,0 for -2. As full vectors `gate[7:0]`, the levels +2,+1,0,-1,-2 give 8'h47, 8'h23, 8'h32, 8'h1C and 8'hB8.
- R7: Outside reset, gate 5 is the inverse of gate 1, gate 4 is the inverse of gate 2, and gate 6 is the inverse of gate 3.
- R8: Gate 7 equals gate1 AND gate2 AND gate3. Gate 8 equals gate4 AND gate5 AND gate6.
- R9: While `rst` is high, all gates are 0 and `level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| ref_in | input | DW | Signed reference sample |
| pk | input | PKW | Carrier peak count; sets the carrier period |
| amp | input | AW | Unsigned amplitude scale; 2^(AW-1) is unity |
| gate | output | 8 | Switch gate commands, bit i-1 is gate i |
| level | output | 3 | Signed commanded output level, -2..+2 |

## Verification
The outcome of each comparison depends on where the shared triangle counter is in its cycle. That phase cannot be seen at the ports. The stimulus therefore pins it by releasing reset just before each sample, which puts the counter at 0 with the carriers at known values. This makes exact ties with carrier edges, and the floor rounding of negative scaled references, land on predictable levels. A small peak count held for a whole period then walks the counter through both reversal points, so a fixed reference shows the up-down order of the carriers in its level sequence.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;
  localparam int NCAR = 4;
  localparam int LVW  = 3;
  typedef logic signed [LVW-1:0] lvl_t;

  // Sum of per-carrier contributions; above[0] is the top carrier.
  function automatic lvl_t sum_levels(input logic [NCAR-1:0] above);
    int s;
    s = (above[0] ? 1 : 0) + (above[1] ? 2 : 1)
      + (above[2] ? 0 : -1) + (above[3] ? -1 : -2);
    return lvl_t'(s);
  endfunction

  // Level to {g8,g7,g6,g5,g4,g3,g2,g1}.
  function automatic logic [7:0] gates_of(input lvl_t lvl);
    logic [2:0] up;  // {g3,g2,g1}
    case (lvl)
      3'b010:  up = 3'b111;
      3'b001:  up = 3'b011;
      3'b000:  up = 3'b010;
      3'b111:  up = 3'b100;
      default: up = 3'b000;
    endcase
    return {&(~up), &up, ~up[2], ~up[0], ~up[1], up};
  endfunction
endpackage

// File: rtl/mlpwm_carrier.sv
module mlpwm_carrier #(
  parameter int PKW = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [PKW-1:0] pk,
  output logic [PKW-1:0] cnt
);
  logic rising;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt    <= '0;
      rising <= 1'b1;
    end else if (rising) begin
      if (cnt < pk) begin
        cnt <= cnt + 1'b1;
      end else begin
        rising <= 1'b0;
        if (cnt != '0) cnt <= cnt - 1'b1;
      end
    end else begin
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        rising <= 1'b1;
        if (pk != '0) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mlpwm_compare.sv
module mlpwm_compare
  import mlpwm_pkg::*;
#(
  parameter int DW  = 12,
  parameter int AW  = 8,
  parameter int PKW = 10
) (
  input  logic signed [DW-1:0] ref_in,
  input  logic [AW-1:0]        amp,
  input  logic [PKW-1:0]       pk,
  input  logic [PKW-1:0]       cnt,
  output logic [NCAR-1:0]      above
);
  localparam int PW = DW + AW + 1;
  localparam int SH = AW - 1;

  logic signed [PW-1:0] ref_x, amp_x, prod, ref_eff, cnt_x, pk_x;

  assign ref_x   = {{(PW-DW){ref_in[DW-1]}}, ref_in};
  assign amp_x   = {{(PW-AW){1'b0}}, amp};
  assign prod    = ref_x * amp_x;
  assign ref_eff = prod >>> SH;
  assign cnt_x   = {{(PW-PKW){1'b0}}, cnt};
  assign pk_x    = {{(PW-PKW){1'b0}}, pk};

  for (genvar j = 0; j < NCAR; j++) begin : g_car
    logic signed [PW-1:0] car;
    if (j == 0) begin : g_top
      assign car = cnt_x + pk_x;
    end else if (j == 1) begin : g_upmid
      assign car = cnt_x;
    end else if (j == 2) begin : g_lomid
      assign car = cnt_x - pk_x;
    end else begin : g_bot
      assign car = cnt_x - (pk_x <<< 1);
    end
    assign above[j] = ref_eff > car;
  end
endmodule

// File: rtl/mlpwm_gate_map.sv
module mlpwm_gate_map
  import mlpwm_pkg::*;
(
  input  lvl_t       lvl,
  output logic [7:0] gate
);
  assign gate = gates_of(lvl);
endmodule

// File: rtl/mlpwm_leg.sv
module mlpwm_leg
  import mlpwm_pkg::*;
#(
  parameter int DW  = 12,
  parameter int AW  = 8,
  parameter int PKW = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic signed [DW-1:0]  ref_in,
  input  logic [PKW-1:0]        pk,
  input  logic [AW-1:0]         amp,
  output logic [7:0]            gate,
  output logic signed [LVW-1:0] level
);
  logic [PKW-1:0]  car_cnt;
  logic [NCAR-1:0] above_c, above_q;
  lvl_t            lvl_c;
  logic [7:0]      gate_c;

  mlpwm_carrier #(.PKW(PKW)) u_carrier (
    .clk(clk), .rst(rst), .pk(pk), .cnt(car_cnt)
  );

  mlpwm_compare #(.DW(DW), .AW(AW), .PKW(PKW)) u_compare (
    .ref_in(ref_in), .amp(amp), .pk(pk), .cnt(car_cnt), .above(above_c)
  );

  assign lvl_c = sum_levels(above_c);

  mlpwm_gate_map u_gate_map (.lvl(lvl_c), .gate(gate_c));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      above_q <= '0;
      level   <= '0;
      gate    <= '0;
    end else begin
      above_q <= above_c;
      level   <= lvl_c;
      gate    <= gate_c;
    end
  end
endmodule

// File: rtl/mlpwm_leg_chk.sv
module mlpwm_leg_chk #(
  parameter int PKW = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [PKW-1:0]    pk,
  input logic [PKW-1:0]    cnt,
  input logic [3:0]        above_q,
  input logic [7:0]        gate,
  input logic signed [2:0] level
);
  a_r1_carrier_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pk) != '0 && $stable(pk)) |->
      (cnt == $past(cnt) + 1 || cnt + 1 == $past(cnt)));

  a_r4_stack_order: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((!above_q[0] || above_q[1]) && (!above_q[1] || above_q[2])
                     && (!above_q[2] || above_q[3])));

  a_r5_level_range: assert property (@(posedge clk) disable iff (rst)
    level >= -3'sd2 && level <= 3'sd2);

  a_r5_level_sum: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (int'(level) == $countones(above_q) - 2));

  a_r7_pairs: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (gate[0] != gate[4] && gate[1] != gate[3] && gate[2] != gate[5]));

  a_r8_products: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (gate[6] == (gate[0] & gate[1] & gate[2])
                     && gate[7] == (gate[3] & gate[4] & gate[5])));
endmodule

bind mlpwm_leg mlpwm_leg_chk #(.PKW(PKW)) u_chk (
  .clk(clk), .rst(rst), .pk(pk), .cnt(car_cnt),
  .above_q(above_q), .gate(gate), .level(level)
);

// File: tb/mlpwm_leg_bench.sv
module mlpwm_leg_bench;
  localparam int DW = 12, AW = 8, PKW = 10;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic signed [DW-1:0] ref_in = '0;
  logic [PKW-1:0]       pk = '0;
  logic [AW-1:0]        amp = 8'd128;
  logic [7:0]           gate;
  logic signed [2:0]    level;

  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  mlpwm_leg #(.DW(DW), .AW(AW), .PKW(PKW)) u_mlpwm_leg (
    .clk(clk), .rst(rst), .ref_in(ref_in), .pk(pk), .amp(amp),
    .gate(gate), .level(level)
  );

  // Vector table, pk=100, counter at 0 so carriers are 100,0,-100,-200 (R2).
  localparam int NV = 15;
  localparam int V_REF[NV] = '{150, 100, 50, 0, -1, -100, -150, -200, -2048,
                               300, 199, -201, -198, 60, 2047};
  localparam int V_AMP[NV] = '{128, 128, 128, 128, 128, 128, 128, 128, 128,
                               64, 64, 64, 64, 255, 0};
  localparam int V_LVL[NV] = '{2, 1, 1, 0, 0, -1, -1, -2, -2,
                               2, 1, -1, 0, 2, 0};

  function automatic logic [7:0] want_gate(input int l);
    case (l)
      2:       return 8'h47;
      1:       return 8'h23;
      0:       return 8'h32;
      -1:      return 8'h1C;
      default: return 8'hB8;
    endcase
  endfunction

  task automatic check_lvl(input string tag, input int exp_l);
    checks++;
    if (int'(level) != exp_l || gate != want_gate(exp_l)) begin
      failures++;
      $display("FAIL %s: level=%0d gate=%h expected level=%0d gate=%h",
               tag, level, gate, exp_l, want_gate(exp_l));
    end
  endtask

  task automatic restart(input int p, input int a, input int r);
    @(negedge clk);
    rst = 1'b1; pk = PKW'(p); amp = AW'(a); ref_in = DW'(r);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    // R9: reset state
    @(negedge clk);
    ref_in = 12'sd2047; pk = 10'd5; amp = 8'd128;
    @(negedge clk);
    checks++;
    if (gate != 8'h00 || level != 3'sd0) begin
      failures++;
      $display("FAIL R9 reset: gate=%h level=%0d expected gate=00 level=0", gate, level);
    end

    // R3 R4 R5 R6: table walk
    for (int i = 0; i < NV; i++) begin
      restart(100, V_AMP[i], V_REF[i]);
      check_lvl($sformatf("R4/R3/R6 vec%0d ref=%0d amp=%0d", i, V_REF[i], V_AMP[i]), V_LVL[i]);
    end

    // R1 R2: pk=3, ref=2, counter 0,1,2,3,2,1,0,1,2
    begin
      int seq[9] = '{1, 1, 0, 0, 0, 1, 1, 1, 0};
      restart(3, 128, 2);
      for (int k = 0; k < 9; k++) begin
        check_lvl($sformatf("R1 triangle step %0d", k), seq[k]);
        @(negedge clk);
      end
    end

    // R1: pk=0 freezes carriers at 0; ref 1 passes all, ref 0 ties all
    restart(0, 128, 1);
    for (int k = 0; k < 3; k++) begin
      check_lvl("R1 zero peak above", 2);
      @(negedge clk);
    end
    ref_in = 12'sd0;
    @(negedge clk);
    check_lvl("R1 zero peak tie", -2);

    // R5 R7 R8: slow ramp sweep
    restart(20, 128, -70);
    for (int r = -70; r <= 70; r++) begin
      ref_in = DW'(r);
      for (int h = 0; h < 3; h++) begin
        @(negedge clk);
        checks++;
        if (level < -3'sd2 || level > 3'sd2) begin
          failures++;
          $display("FAIL R5 range: level=%0d expected -2..2", level);
        end
        checks++;
        if (gate[0] == gate[4] || gate[1] == gate[3] || gate[2] == gate[5]) begin
          failures++;
          $display("FAIL R7 pairs: gate=%h expected complementary pairs", gate);
        end
        checks++;
        if (gate[6] != (gate[0] & gate[1] & gate[2]) || gate[7] != (gate[3] & gate[4] & gate[5])) begin
          failures++;
          $display("FAIL R8 products: gate=%h expected g7=%b g8=%b", gate,
                   gate[0] & gate[1] & gate[2], gate[3] & gate[4] & gate[5]);
        end
      end
    end

    // R9: reset asserted mid-run clears outputs
    ref_in = 12'sd2047;
    @(negedge clk);
    rst = 1'b1;
    #1;
    checks++;
    if (gate != 8'h00 || level != 3'sd0) begin
      failures++;
      $display("FAIL R9 async reset: gate=%h level=%0d expected gate=00 level=0", gate, level);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule